// File: doc/BRIEF.md
# System Clock Source Controller

This block produces the system clock of a chip from one of three sources. The sources are an internal oscillator, a low-speed oscillator and an external clock input. Software programs it through a small register port. A selection register holds the chosen source, the division ratio and a second source/ratio pair that is applied when the core wakes from sleep. An oscillator register holds one enable bit and one stop-in-sleep bit for each source. The per-source enable outputs drive the oscillator models. Each model answers with a ready flag once its clock is running.

All logic runs on one fast reference clock `clk`. The three source clocks are brought in through synchronisers and divided by counting their edges. The divided output is therefore a registered signal with a 50% duty cycle. When the selection changes, the output first finishes its high phase. It then holds low until the new source reports ready, and the divider restarts from zero. No shortened high pulse can appear. A status output names the source that is currently driving the output.

Entering sleep gates off every source whose stop-in-sleep bit is set. A wake-up strobe restores those sources. If the wake-up mode bit is set, the wake-up strobe also copies the wake-up pair into the live selection.

Top module: `sysclk_src_ctrl`

## Requirements
- R1: After reset, the selection register (address 0) reads 0x0000 and the oscillator register (address 1) reads 0x0001. `active_src` is 0 and `src_en` is 3'b001. Once the internal source is ready, `sys_clk` runs at the internal source rate divided by 1.
- R2: Source codes in bits [1:0] of the selection register are: 0 = internal, 1 = low-speed, 2 = external. A write with code 3 leaves the live source and divider unchanged.
- R3: Divider code d in bits [5:4] divides the internal source by 2^d (codes 0..3 give 1, 2, 4, 8). The output has a 50% duty cycle.
- R4: The low-speed source accepts divider codes 0 (divide by 1) and 1 (divide by 2). The external source accepts only code 0. A write with an illegal source/divider pair keeps the previous live pair. The wake-up pair (source in bits [9:8], divider in bits [13:12]) is checked the same way and on its own. The wake-up mode bit (bit 15) is always written.
- R5: Accepting a selection, from a write or from a wake-up reload, sets the enable bit of the chosen source. An oscillator-register write cannot clear the enable bit of the selected source. Enables are in bits [2:0] of address 1, one bit per source code.
- R6: Reserved bits read 0 and ignore writes. In the selection register these are bits 2, 3, 6, 7, 10, 11 and 14. In the oscillator register they are bits 3 to 7 and 11 to 15.
- R7: A `sleep_req` strobe forces `src_en` low, within two cycles, for every source whose stop-in-sleep bit (address 1, bits [10:8]) is 1. The stored enable bits are unchanged.
- R8: A `wake_req` strobe restores `src_en` to the stored enables. When the wake-up mode bit is 1, it also loads the wake-up pair into the live source and divider.
- R9: With the wake-up mode bit at 0, `wake_req` leaves the live source and divider unchanged.
- R10: A change of source or divider never produces a high pulse shorter than the shortest half-period of the old or the new setting. `active_src` changes only while `sys_clk` is low.
- R11: `active_src` reports the source that drives `sys_clk`, once the new source is ready and the switch has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = selection register, 1 = oscillator register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for `reg_addr` |
| sleep_req | input | 1 | Sleep entry strobe |
| wake_req | input | 1 | Wake-up strobe |
| src_clk | input | 3 | Source clocks, indexed by source code |
| src_ready | input | 3 | Per-source running flags |
| src_en | output | 3 | Per-source enable to the oscillators |
| sys_clk | output | 1 | Divided system clock (registered) |
| active_src | output | 2 | Source currently driving `sys_clk` |

## Verification
The assertions check the following on every cycle:
- the live and wake-up selections always hold a legal source/divider pair;
- a wake-up with the mode bit set reloads the pair, and one with the bit clear keeps it;
- a sleep strobe clears the enables of sources marked stop-in-sleep;
- the status output only moves while the clock is low.

Only the directed scenarios can show the other behaviours:
- the actual output periods and duty cycle for each source and ratio;
- the shortest high pulse across a switch;
- the automatic starting of a selected source;
- the exact read-back values after rejected and reserved-bit writes.

// File: rtl/sysclk_src_pkg.sv
package sysclk_src_pkg;
  localparam int NSRC  = 3;
  localparam int SEL_W = 2;
  localparam int DIV_W = 2;
  localparam int CNT_W = 3;

  localparam logic [SEL_W-1:0] SRC_INT = 2'd0;
  localparam logic [SEL_W-1:0] SRC_LOW = 2'd1;
  localparam logic [SEL_W-1:0] SRC_EXT = 2'd2;

  function automatic logic pair_ok(input logic [SEL_W-1:0] s, input logic [DIV_W-1:0] d);
    case (s)
      SRC_INT: pair_ok = 1'b1;
      SRC_LOW: pair_ok = (d <= 2'd1);
      SRC_EXT: pair_ok = (d == 2'd0);
      default: pair_ok = 1'b0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] last_edge(input logic [DIV_W-1:0] d);
    last_edge = CNT_W'((1 << d) - 1);
  endfunction
endpackage

// File: rtl/sysclk_src_sync.sv
module sysclk_src_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= '0;
      else if (i == 0) chain[i] <= d;
      else chain[i] <= chain[(i == 0) ? 0 : i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sysclk_src_regs.sv
module sysclk_src_regs
  import sysclk_src_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             sleep_req,
  input  logic             wake_req,
  output logic [SEL_W-1:0] sel_src,
  output logic [DIV_W-1:0] sel_div,
  output logic [NSRC-1:0]  src_en
);
  logic [SEL_W-1:0] src_q, src_n, wsrc_q, wsrc_n;
  logic [DIV_W-1:0] div_q, div_n, wdiv_q, wdiv_n;
  logic             wmode_q, wmode_n, asleep_q, asleep_n;
  logic [NSRC-1:0]  en_q, en_n, stop_q, stop_n, src_en_q;
  logic [DW-1:0]    rdata_q, sel_word, osc_word;

  always_comb begin
    src_n = src_q; div_n = div_q; wsrc_n = wsrc_q; wdiv_n = wdiv_q;
    wmode_n = wmode_q; en_n = en_q; stop_n = stop_q; asleep_n = asleep_q;
    if (sleep_req) asleep_n = 1'b1;
    if (wake_req) begin
      asleep_n = 1'b0;
      if (wmode_q) begin
        src_n = wsrc_q;
        div_n = wdiv_q;
      end
    end
    if (reg_wr && !reg_addr) begin
      if (pair_ok(reg_wdata[1:0], reg_wdata[5:4])) begin
        src_n = reg_wdata[1:0];
        div_n = reg_wdata[5:4];
      end
      if (pair_ok(reg_wdata[9:8], reg_wdata[13:12])) begin
        wsrc_n = reg_wdata[9:8];
        wdiv_n = reg_wdata[13:12];
      end
      wmode_n = reg_wdata[15];
    end
    if (reg_wr && reg_addr) begin
      en_n   = reg_wdata[NSRC-1:0];
      stop_n = reg_wdata[8 +: NSRC];
    end
    en_n = en_n | (NSRC'(1) << src_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_INT; div_q <= '0; wsrc_q <= SRC_INT; wdiv_q <= '0;
      wmode_q <= 1'b0; en_q <= NSRC'(1); stop_q <= '0; asleep_q <= 1'b0;
      src_en_q <= NSRC'(1); rdata_q <= '0;
    end else begin
      src_q <= src_n; div_q <= div_n; wsrc_q <= wsrc_n; wdiv_q <= wdiv_n;
      wmode_q <= wmode_n; en_q <= en_n; stop_q <= stop_n; asleep_q <= asleep_n;
      src_en_q <= en_n & ~(stop_n & {NSRC{asleep_n}});
      rdata_q <= reg_addr ? osc_word : sel_word;
    end
  end

  assign sel_word = DW'({wmode_q, 1'b0, wdiv_q, 2'b00, wsrc_q, 2'b00, div_q, 2'b00, src_q});
  assign osc_word = DW'({5'b0, stop_q, 5'b0, en_q});

  assign reg_rdata = rdata_q;
  assign sel_src   = src_q;
  assign sel_div   = div_q;
  assign src_en    = src_en_q;

  // R4: both stored pairs are always legal
  assert_sel_legal_R4: assert property (@(posedge clk) disable iff (rst)
    pair_ok(src_q, div_q) && pair_ok(wsrc_q, wdiv_q));

  // R8: wake-up with mode set reloads the live pair
  assert_wake_reload_R8: assert property (@(posedge clk) disable iff (rst)
    (wake_req && wmode_q && !reg_wr) |=> (src_q == $past(wsrc_q)) && (div_q == $past(wdiv_q)));

  // R9: wake-up with mode clear keeps the live pair
  assert_wake_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wake_req && !wmode_q && !reg_wr) |=> $stable(src_q) && $stable(div_q));

  // R7: sleep entry removes stop-in-sleep sources from the enables
  assert_sleep_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && !wake_req && !reg_wr) |=> ((src_en_q & stop_q) == '0));
endmodule

// File: rtl/sysclk_src_gen.sv
module sysclk_src_gen
  import sysclk_src_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_s,
  input  logic [NSRC-1:0]  rdy_s,
  input  logic [SEL_W-1:0] req_src,
  input  logic [DIV_W-1:0] req_div,
  output logic             sys_clk,
  output logic [SEL_W-1:0] active_src
);
  typedef enum logic [1:0] {ST_RUN, ST_DRAIN, ST_HOLD} st_e;

  st_e              st_q;
  logic [SEL_W-1:0] cur_src_q, act_q;
  logic [DIV_W-1:0] cur_div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NSRC-1:0]  prev_q;
  logic             clk_q, edge_hit, change;

  assign edge_hit = src_s[cur_src_q] ^ prev_q[cur_src_q];
  assign change   = (req_src != cur_src_q) || (req_div != cur_div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_HOLD; cur_src_q <= SRC_INT; cur_div_q <= '0; act_q <= SRC_INT;
      cnt_q <= '0; prev_q <= '0; clk_q <= 1'b0;
    end else begin
      prev_q <= src_s;
      case (st_q)
        ST_RUN, ST_DRAIN: begin
          if (st_q == ST_DRAIN && !clk_q) begin
            st_q      <= ST_HOLD;
            cur_src_q <= req_src;
            cur_div_q <= req_div;
            cnt_q     <= '0;
          end else begin
            if (change) st_q <= ST_DRAIN;
            if (edge_hit) begin
              if (cnt_q == last_edge(cur_div_q)) begin
                cnt_q <= '0;
                clk_q <= ~clk_q;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
        end
        default: begin
          cnt_q <= '0;
          if (change) begin
            cur_src_q <= req_src;
            cur_div_q <= req_div;
          end else if (rdy_s[cur_src_q]) begin
            st_q  <= ST_RUN;
            act_q <= cur_src_q;
          end
        end
      endcase
    end
  end

  assign sys_clk    = clk_q;
  assign active_src = act_q;

  // R10: the status only moves while the output clock is low
  assert_switch_low_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> !clk_q);
endmodule

// File: rtl/sysclk_src_ctrl.sv
module sysclk_src_ctrl
  import sysclk_src_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic [2:0]    src_clk,
  input  logic [2:0]    src_ready,
  output logic [2:0]    src_en,
  output logic          sys_clk,
  output logic [1:0]    active_src
);
  localparam int SYNC_W = 2 * NSRC;

  logic [SEL_W-1:0]  sel_src;
  logic [DIV_W-1:0]  sel_div;
  logic [SYNC_W-1:0] synced;

  sysclk_src_regs #(.DW(DW)) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sleep_req(sleep_req), .wake_req(wake_req),
    .sel_src(sel_src), .sel_div(sel_div), .src_en(src_en)
  );

  sysclk_src_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d({src_ready, src_clk}), .q(synced)
  );

  sysclk_src_gen gen_i (
    .clk(clk), .rst(rst),
    .src_s(synced[NSRC-1:0]), .rdy_s(synced[SYNC_W-1:NSRC]),
    .req_src(sel_src), .req_div(sel_div),
    .sys_clk(sys_clk), .active_src(active_src)
  );
endmodule

// File: tb/sysclk_src_ctrl_tb_top.sv
module sysclk_src_ctrl_tb_top;
  logic        clk = 0, rst = 1;
  logic        reg_wr = 0, reg_addr = 0, sleep_req = 0, wake_req = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [2:0]  src_clk = 0, src_ready = 0, src_en;
  logic        sys_clk;
  logic [1:0]  active_src;
  int          n_chk = 0, n_bad = 0, hi_min = 1000, hi_run = 0;
  int          half [3] = '{2, 8, 3};
  int          tcnt [3] = '{0, 0, 0};
  int          rcnt [3] = '{0, 0, 0};

  always #5 clk = ~clk;

  sysclk_src_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sleep_req(sleep_req), .wake_req(wake_req),
    .src_clk(src_clk), .src_ready(src_ready), .src_en(src_en),
    .sys_clk(sys_clk), .active_src(active_src)
  );

  // oscillator models: ready 4 cycles after enable, clock runs only when ready
  always @(posedge clk) begin
    for (int s = 0; s < 3; s++) begin
      if (!src_en[s]) begin rcnt[s] <= 0; src_ready[s] <= 1'b0; end
      else begin
        if (rcnt[s] < 4) rcnt[s] <= rcnt[s] + 1;
        src_ready[s] <= (rcnt[s] >= 4);
      end
      if (!src_ready[s]) begin src_clk[s] <= 1'b0; tcnt[s] <= 0; end
      else if (tcnt[s] == half[s] - 1) begin src_clk[s] <= ~src_clk[s]; tcnt[s] <= 0; end
      else tcnt[s] <= tcnt[s] + 1;
    end
  end

  // shortest high pulse monitor
  always @(negedge clk) begin
    if (sys_clk) hi_run <= hi_run + 1;
    else if (hi_run != 0) begin
      if (hi_run < hi_min) hi_min <= hi_run;
      hi_run <= 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic a, output int v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); @(negedge clk); v = reg_rdata;
  endtask

  task automatic pulse_sleep();
    @(negedge clk); sleep_req = 1; @(negedge clk); sleep_req = 0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_req = 1; @(negedge clk); wake_req = 0;
  endtask

  task automatic meas(output int per, output int hi);
    int t = 0;
    bit low_seen = 0;
    per = 0; hi = 0;
    while (sys_clk !== 1'b0 && t < 600) begin @(negedge clk); t++; end
    while (sys_clk !== 1'b1 && t < 600) begin @(negedge clk); t++; end
    per = 1; hi = 1;
    while (t < 600) begin
      @(negedge clk); t++;
      if (sys_clk && low_seen) break;
      if (sys_clk) hi++; else low_seen = 1;
      per++;
    end
  endtask

  task automatic wait_active(input int s, input string req);
    int t = 0;
    while (active_src != 2'(s) && t < 600) begin @(negedge clk); t++; end
    chk(req, active_src, s);
  endtask

  task automatic check_rate(input int s, input int per_exp, input string req);
    int per, hi;
    wait_active(s, req);
    meas(per, hi);
    meas(per, hi);
    chk(req, per, per_exp);
    chk(req, hi, per_exp / 2);
  endtask

  task automatic t_reset();
    int v;
    rd(0, v); chk("R1 sel reset", v, 16'h0000);
    rd(1, v); chk("R1 osc reset", v, 16'h0001);
    chk("R1 src_en reset", src_en, 3'b001);
    check_rate(0, 4, "R1 internal div1");
  endtask

  task automatic t_divider();
    int v;
    wr(0, 16'h0010); check_rate(0, 8, "R3 div2");
    wr(0, 16'h0020); check_rate(0, 16, "R3 div4");
    wr(0, 16'h0030); check_rate(0, 32, "R3 div8");
    hi_min = 1000;
    wr(0, 16'h0000); check_rate(0, 4, "R3 div1");
    chk("R10 min high pulse", hi_min, 2);
  endtask

  task automatic t_reject();
    int v;
    wr(0, 16'h0003); rd(0, v); chk("R2 code3 ignored", v, 16'h0000);
    wr(0, 16'h0021); rd(0, v); chk("R4 low div4 ignored", v, 16'h0000);
    wr(0, 16'h0012); rd(0, v); chk("R4 ext div2 ignored", v, 16'h0000);
    wr(0, 16'h0300); rd(0, v); chk("R4 wake pair ignored", v, 16'h0000);
    wr(0, 16'h6CCC); rd(0, v); chk("R6 sel reserved", v, 16'h2000);
    wr(1, 16'hFFFF); rd(1, v); chk("R6 osc reserved", v, 16'h0707);
    wr(1, 16'h0001); wr(0, 16'h0000);
    chk("R2 still internal", active_src, 0);
  endtask

  task automatic t_sources();
    int v;
    hi_min = 1000;
    wr(0, 16'h0002); rd(1, v); chk("R5 ext autostart", v, 16'h0005);
    check_rate(2, 6, "R11 external div1");
    chk("R10 min high on switch", hi_min, 2);
    wr(1, 16'h0000); rd(1, v); chk("R5 selected enable kept", v, 16'h0004);
    wr(0, 16'h0011); check_rate(1, 32, "R4 low div2");
    rd(1, v); chk("R5 low autostart", v, 16'h0006);
    wr(0, 16'h0000); check_rate(0, 4, "R5 internal restart");
    rd(1, v); chk("R5 internal autostart", v, 16'h0007);
  endtask

  task automatic t_sleep_reload();
    int v;
    wr(1, 16'h0207);
    wr(0, 16'h9100);
    pulse_sleep(); @(negedge clk);
    chk("R7 sleep gating", src_en, 3'b101);
    rd(1, v); chk("R7 enables kept", v, 16'h0207);
    pulse_wake(); @(negedge clk);
    chk("R8 enables restored", src_en, 3'b111);
    rd(0, v); chk("R8 wake reload", v, 16'h9111);
    check_rate(1, 32, "R8 low div2 after wake");
  endtask

  task automatic t_wake_off();
    int v;
    wr(0, 16'h0200); check_rate(0, 4, "R9 internal before sleep");
    pulse_sleep(); @(negedge clk);
    pulse_wake(); @(negedge clk);
    rd(0, v); chk("R9 selection unchanged", v, 16'h0200);
    check_rate(0, 4, "R9 still internal");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    t_reset();
    t_divider();
    t_reject();
    t_sources();
    t_sleep_reload();
    t_wake_off();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule